// File: doc/BRIEF.md
# Single-Item Shared Buffer with Selectable Access Protocol

This block passes one data item at a time from a writer to a reader through a single storage register and a one-bit unread/read flag. A mode code, captured while reset is held, chooses which side may be held off and which side may overwrite or re-read the stored item. The five protocols follow a wait/no-wait classification. An access that overwrites or consumes data never waits on the writer side, and a consuming read may wait. Accesses that do neither have the opposite property.

Each side raises its request and keeps it high. When the block grants the access, it answers with a one-cycle acknowledge in the following cycle, and the requester then drops its request. A request that is held off gets no acknowledge and leaves the state unchanged until it is withdrawn. The read data is registered and is valid while the read acknowledge is high.

Top module: `shared_item_buf`

## Requirements
- R1: After reset, wr_ack and rd_ack are 0, rd_data is 0, the stored item is zero and the flag reads "read" (no unread item).
- R2: A granted access produces wr_ack or rd_ack high for exactly one cycle, in the cycle after the grant edge. No acknowledge appears without its request, and a request still high during its acknowledge is not granted a second time.
- R3: Signal (mode code 0): every write is granted and replaces the item. A read is granted only while an unread item exists, and a granted read marks the item read.
- R4: Pool (mode code 1): writes and reads are always granted. Writes replace the item, and reads may return the same item again, including the reset zero before any write.
- R5: Channel (mode code 2): a write is held while an unread item exists and a read is held while none exists, so each item is delivered exactly once.
- R6: Command (mode code 3): a write is held while an unread item exists. Reads are always granted and may return the same item again.
- R7: Constant (mode code 4): only the first write after reset is granted and all later writes are held. Reads are always granted, and reads before the write return zero.
- R8: When a read and a write are granted at the same edge, the read returns the value stored before that edge, the write's value is stored, and the item is left unread.
- R9: The mode code is taken only while reset is in effect, and later changes to mode_sel have no effect. Codes 5 to 7 behave as Signal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_sel | input | 3 | Protocol code, captured while reset is in effect |
| wr_req | input | 1 | Write request, held until wr_ack |
| wr_data | input | DW | Data to store |
| wr_ack | output | 1 | One-cycle write acknowledge |
| rd_req | input | 1 | Read request, held until rd_ack |
| rd_ack | output | 1 | One-cycle read acknowledge |
| rd_data | output | DW | Read value, valid with rd_ack |

## Verification
The hardest case to reach is a read and a write granted at the same edge while an item is already stored. It needs a protocol that lets both sides through, a prepared unread item, and both requests raised at the same clock edge. The bench does this with a combined access step in a fixed script, and it runs that script once for every one of the eight mode codes. After each reset it also drives mode_sel to a different code, so every pass also shows that the captured protocol holds.

// File: rtl/sib_pkg.sv
package sib_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SIB_SIGNAL   = 3'd0,
    SIB_POOL     = 3'd1,
    SIB_CHANNEL  = 3'd2,
    SIB_COMMAND  = 3'd3,
    SIB_CONSTANT = 3'd4
  } sib_mode_e;

  function automatic sib_mode_e sib_decode(input logic [MODE_W-1:0] code);
    case (code)
      3'd1:    return SIB_POOL;
      3'd2:    return SIB_CHANNEL;
      3'd3:    return SIB_COMMAND;
      3'd4:    return SIB_CONSTANT;
      default: return SIB_SIGNAL;
    endcase
  endfunction
endpackage

// File: rtl/sib_rst_sync.sv
module sib_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb sync_n = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/sib_mode_reg.sv
module sib_mode_reg
  import sib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_sel,
  output sib_mode_e         mode_q
);
  logic      load_en;
  sib_mode_e mode_n;

  always_comb begin
    load_en = !rst_ni;
    mode_n  = load_en ? sib_decode(mode_sel) : mode_q;
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_n;
  end
endmodule

// File: rtl/sib_gate.sv
module sib_gate
  import sib_pkg::*;
(
  input  sib_mode_e mode,
  input  logic      full,
  input  logic      sealed,
  input  logic      wr_req,
  input  logic      wr_ack,
  input  logic      rd_req,
  input  logic      rd_ack,
  output logic      wr_gnt,
  output logic      rd_gnt
);
  logic wr_ok;
  logic rd_ok;

  always_comb begin
    case (mode)
      SIB_POOL:     begin wr_ok = 1'b1;    rd_ok = 1'b1; end
      SIB_CHANNEL:  begin wr_ok = !full;   rd_ok = full; end
      SIB_COMMAND:  begin wr_ok = !full;   rd_ok = 1'b1; end
      SIB_CONSTANT: begin wr_ok = !sealed; rd_ok = 1'b1; end
      default:      begin wr_ok = 1'b1;    rd_ok = full; end
    endcase
    wr_gnt = wr_req && !wr_ack && wr_ok;
    rd_gnt = rd_req && !rd_ack && rd_ok;
  end
endmodule

// File: rtl/sib_store.sv
module sib_store #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_gnt,
  input  logic          rd_gnt,
  input  logic [DW-1:0] wr_data,
  output logic          full_q,
  output logic          sealed_q,
  output logic          wr_ack_q,
  output logic          rd_ack_q,
  output logic [DW-1:0] rd_data_q
);
  logic [DW-1:0] item_q, item_n, rd_data_n;
  logic          full_n, sealed_n;
  logic          item_en, out_en;

  always_comb begin
    item_en   = wr_gnt;
    out_en    = rd_gnt;
    item_n    = item_en ? wr_data : item_q;
    rd_data_n = out_en ? item_q : rd_data_q;
    sealed_n  = sealed_q | wr_gnt;
    if (wr_gnt)      full_n = 1'b1;
    else if (rd_gnt) full_n = 1'b0;
    else             full_n = full_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      item_q    <= '0;
      rd_data_q <= '0;
      full_q    <= 1'b0;
      sealed_q  <= 1'b0;
      wr_ack_q  <= 1'b0;
      rd_ack_q  <= 1'b0;
    end else begin
      item_q    <= item_n;
      rd_data_q <= rd_data_n;
      full_q    <= full_n;
      sealed_q  <= sealed_n;
      wr_ack_q  <= wr_gnt;
      rd_ack_q  <= rd_gnt;
    end
  end
endmodule

// File: rtl/shared_item_buf.sv
module shared_item_buf
  import sib_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              wr_req,
  input  logic [DW-1:0]     wr_data,
  output logic              wr_ack,
  input  logic              rd_req,
  output logic              rd_ack,
  output logic [DW-1:0]     rd_data
);
  logic      rst_ni;
  sib_mode_e mode_q;
  logic      full_q, sealed_q, wr_gnt, rd_gnt;

  sib_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni)
  );

  sib_mode_reg u_mode (
    .clk(clk), .rst_ni(rst_ni), .mode_sel(mode_sel), .mode_q(mode_q)
  );

  sib_gate u_gate (
    .mode(mode_q), .full(full_q), .sealed(sealed_q),
    .wr_req(wr_req), .wr_ack(wr_ack), .rd_req(rd_req), .rd_ack(rd_ack),
    .wr_gnt(wr_gnt), .rd_gnt(rd_gnt)
  );

  sib_store #(.DW(DW)) u_store (
    .clk(clk), .rst_ni(rst_ni), .wr_gnt(wr_gnt), .rd_gnt(rd_gnt),
    .wr_data(wr_data), .full_q(full_q), .sealed_q(sealed_q),
    .wr_ack_q(wr_ack), .rd_ack_q(rd_ack), .rd_data_q(rd_data)
  );
endmodule

// File: rtl/sib_chk.sv
module sib_chk
  import sib_pkg::*;
(
  input logic      clk,
  input logic      rst_ni,
  input sib_mode_e mode_q,
  input logic      full_q,
  input logic      sealed_q,
  input logic      wr_gnt,
  input logic      rd_gnt,
  input logic      wr_req,
  input logic      rd_req,
  input logic      wr_ack,
  input logic      rd_ack
);
  a_r2_wr_ack_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_ack |=> !wr_ack);
  a_r2_rd_ack_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_ack |=> !rd_ack);
  a_r2_wr_ack_had_req: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_ack |-> $past(wr_req));
  a_r2_rd_ack_had_req: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_ack |-> $past(rd_req));
  a_r3_signal_read_waits: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == SIB_SIGNAL && !full_q) |=> !rd_ack);
  a_r5_channel_write_waits: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == SIB_CHANNEL && full_q) |=> !wr_ack);
  a_r6_command_write_waits: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == SIB_COMMAND && full_q) |=> !wr_ack);
  a_r7_constant_one_write: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == SIB_CONSTANT && sealed_q) |=> !wr_ack);
  a_r8_collision_unread: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_gnt && rd_gnt) |=> full_q);
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> $stable(mode_q));
endmodule

bind shared_item_buf sib_chk u_chk (
  .clk(clk), .rst_ni(rst_ni), .mode_q(mode_q), .full_q(full_q),
  .sealed_q(sealed_q), .wr_gnt(wr_gnt), .rd_gnt(rd_gnt),
  .wr_req(wr_req), .rd_req(rd_req), .wr_ack(wr_ack), .rd_ack(rd_ack)
);

// File: tb/shared_item_buf_tb.sv
module shared_item_buf_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    mode_sel;
  logic          wr_req, rd_req;
  logic [DW-1:0] wr_data;
  logic          wr_ack, rd_ack;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          m_mode;
  bit          m_full, m_sealed;
  logic [7:0]  m_data;

  always #2 clk = ~clk;

  shared_item_buf #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input int code);
    case (code)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R9";
    endcase
  endfunction

  // Protocol table from the requirements, for the effective mode (codes 5..7 = Signal)
  function automatic bit exp_wr_ok();
    case (m_mode)
      2, 3: return !m_full;
      4: return !m_sealed;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit exp_rd_ok();
    case (m_mode)
      1, 3, 4: return 1'b1;
      default: return m_full;
    endcase
  endfunction

  task automatic access(input bit do_wr, input bit do_rd, input logic [7:0] d, input string tag);
    bit wok, rok;
    logic [7:0] old;
    bit wa, ra;
    logic [7:0] rv;
    wok = do_wr && exp_wr_ok();
    rok = do_rd && exp_rd_ok();
    old = m_data;
    @(negedge clk);
    wr_req = do_wr; rd_req = do_rd; wr_data = d;
    @(negedge clk);
    wa = wr_ack; ra = rd_ack; rv = rd_data;
    wr_req = 1'b0; rd_req = 1'b0;
    if (do_wr) chk(wa == wok, {tag, " write grant"}, wa, wok);
    else       chk(wa == 1'b0, "R2 no wr_ack without request", wa, 0);
    if (do_rd) chk(ra == rok, {tag, " read grant"}, ra, rok);
    else       chk(ra == 1'b0, "R2 no rd_ack without request", ra, 0);
    if (rok) chk(rv == old, (do_wr && wok) ? "R8 collision read value" : {tag, " read value"}, rv, old);
    @(negedge clk);
    chk(!wr_ack && !rd_ack, "R2 ack lasts one cycle", {wr_ack, rd_ack}, 0);
    if (wok) begin m_data = d; m_sealed = 1'b1; end
    if (wok)      m_full = 1'b1;
    else if (rok) m_full = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; mode_sel = '0; wr_req = 1'b0; rd_req = 1'b0; wr_data = '0;
    for (int code = 0; code < 8; code++) begin
      string t;
      logic [7:0] base;
      t = mode_tag(code);
      base = 8'(code * 16);
      m_mode = (code <= 4) ? code : 0;
      m_full = 1'b0; m_sealed = 1'b0; m_data = '0;
      @(negedge clk);
      rst_n = 1'b0; mode_sel = 3'(code);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      mode_sel = 3'(code) ^ 3'b101;  // R9: later change must be ignored
      chk(!wr_ack && !rd_ack, "R1 acks idle after reset", {wr_ack, rd_ack}, 0);
      chk(rd_data == 8'h00, "R1 rd_data zero after reset", rd_data, 0);
      access(0, 1, 8'h00,        t);
      access(1, 0, base + 8'h1,  t);
      access(1, 0, base + 8'h2,  t);
      access(0, 1, 8'h00,        t);
      access(0, 1, 8'h00,        t);
      access(1, 1, base + 8'h3,  t);
      access(0, 1, 8'h00,        t);
      access(1, 0, base + 8'h4,  t);
      access(1, 1, base + 8'h5,  t);
      access(0, 1, 8'h00,        t);
      mode_sel = 3'(code) ^ 3'b011;  // R9: another change mid-run
      access(1, 0, base + 8'h6,  t);
      access(0, 1, 8'h00,        t);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule